// File: doc/BRIEF.md
# SPI Master Serial Clock Rate Generator

This block derives the serial clock of an SPI controller from the peripheral clock. An 8-bit rate value `n` and a 2-bit binary divider select `N` together set the clock. The linear stage divides by `n+1` and the binary stage by `2^N`. Each half period of the serial clock therefore lasts `(n+1)·2^N` peripheral clocks, and each full bit period lasts `2·(n+1)·2^N`. The division ratio spans 2 to 4096.

The generator runs only while the controller is both enabled and set as master. In any other case it rests in its idle state. In idle the counter is cleared, the serial clock stays low and no strobes appear. In slave mode the serial clock comes from the external master, so the rate value and the divider select have no effect there.

The rate value can be written only while the generator is not running as an enabled master. The divider select normally comes from the active command. It is sampled on entry into the running state and again at each full bit-period boundary, so a change never shortens a pulse.

The controller has three states:
- `S_IDLE`: generator off. It moves to `S_LOW` once the controller is both enabled and master.
- `S_LOW`: serial clock low. A tick moves it to `S_HIGH` and issues a rising strobe.
- `S_HIGH`: serial clock high. A tick moves it back to `S_LOW`, issues a falling strobe and re-samples the divider select.

From `S_LOW` or `S_HIGH`, losing either the enable or the master condition returns the controller to `S_IDLE`.

Top module: `sck_rate_gen`

## Requirements
- R1: After reset the rate value is 255, the serial clock is low, `sck_active` is low and no strobe is asserted. With the reset rate value and a divider select of 0, the full period is 512 clocks.
- R2: While running, `half_tick` pulses once every `(n+1)·2^N` clocks. Consecutive `sck_rise` strobes are `2·(n+1)·2^N` clocks apart.
- R3: The division ratio covers the ends of its range and the points between them. For n=0 and N=0 it is 2. For n=2 and N=0 it is 6. For n=5 and N=2 it is 48. For n=255 and N=3 it is 4096.
- R4: A write to the rate value is ignored while `master_sel` and `gen_en` are both 1. At all other times a write is accepted.
- R5: When `gen_en` is 0 or `master_sel` is 0, the generator goes idle on the next clock. In idle the counter is cleared, `sck_out`, `sck_active`, `half_tick`, `sck_rise` and `sck_fall` are all 0, and the rate value and the divider select have no effect.
- R6: A change of `div_sel` is taken only at a full bit-period boundary, on the falling tick. The half period that is in progress keeps its old length.
- R7: `sck_rise` is asserted on a tick in the low half, and `sck_out` is 1 from the next clock on. `sck_fall` is asserted on a tick in the high half, and `sck_out` is 0 from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_wr | input | 1 | Write strobe for the rate value |
| rate_wdata | input | 8 | Rate value n to write |
| div_sel | input | 2 | Binary divider select N from the active command |
| master_sel | input | 1 | 1 selects master mode |
| gen_en | input | 1 | Controller enable |
| sck_out | output | 1 | Generated serial clock, idle low |
| sck_active | output | 1 | Serial clock enable, high while generating |
| half_tick | output | 1 | Half-period tick |
| sck_rise | output | 1 | Strobe: serial clock toggles high next clock |
| sck_fall | output | 1 | Strobe: serial clock toggles low next clock |

## Verification
The period is measured between rising strobes for all four divider selects and for rate values 0, 2, 5, 17 and 255. These points separate errors in the `n+1` term from errors in the power-of-two term, and they expose mistakes at both ends of the ratio range. A divider select change made during a high half tells boundary sampling apart from immediate sampling, because the high half keeps its old length and the following low half takes the new one. Rate writes are tried with the generator running as master, as an enabled slave and while disabled, and the result is judged by the period measured afterwards. Slave mode and the disabled state are checked for the absence of any strobe or clock activity.

// File: rtl/sckg_pkg.sv
package sckg_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2
    } sck_state_t;
endpackage

// File: rtl/sckg_rate_reg.sv
module sckg_rate_reg #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [RATE_W-1:0] wdata,
    input  logic              lock,
    output logic [RATE_W-1:0] rate_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rate_q <= '1;
        else if (wr && !lock)
            rate_q <= wdata;
    end

    // R4: no update while locked
    a_r4_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(rate_q));
endmodule

// File: rtl/sckg_half_cnt.sv
module sckg_half_cnt #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half_len,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == half_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R2: count stays below the half-period length while running
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < half_len));
endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen #(
    parameter int RATE_W = 8,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_wdata,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              master_sel,
    input  logic              gen_en,
    output logic              sck_out,
    output logic              sck_active,
    output logic              half_tick,
    output logic              sck_rise,
    output logic              sck_fall
);
    import sckg_pkg::*;

    localparam int MAX_SHIFT = (1 << DIV_W) - 1;
    localparam int CNT_W     = RATE_W + 1 + MAX_SHIFT;

    sck_state_t       state, state_nx;
    logic             active;
    logic             run;
    logic             tick_w;
    logic [RATE_W-1:0] rate_q;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  half_len;
    logic              div_load;

    assign active   = gen_en && master_sel;
    assign run      = active && (state != S_IDLE);
    assign half_len = (CNT_W'(rate_q) + 1'b1) << div_q;
    assign div_load = (state == S_IDLE && active) || (state == S_HIGH && tick_w);

    sckg_rate_reg #(.RATE_W(RATE_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (rate_wr),
        .wdata  (rate_wdata),
        .lock   (active),
        .rate_q (rate_q)
    );

    sckg_half_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_len (half_len),
        .tick     (tick_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_load)
            div_q <= div_sel;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (active) state_nx = S_LOW;
            S_LOW:   if (!active) state_nx = S_IDLE;
                     else if (tick_w) state_nx = S_HIGH;
            S_HIGH:  if (!active) state_nx = S_IDLE;
                     else if (tick_w) state_nx = S_LOW;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        sck_out    = (state == S_HIGH);
        sck_active = (state != S_IDLE);
        half_tick  = tick_w;
        sck_rise   = tick_w && (state == S_LOW);
        sck_fall   = tick_w && (state == S_HIGH);
    end

    // R5: leaving master-enabled operation idles the generator
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!sck_active && !sck_out && !half_tick));
    // R7: a rising strobe raises the clock on the next cycle
    a_r7_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_rise && active) |=> sck_out);
    // R7: a falling strobe lowers the clock on the next cycle
    a_r7_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
        sck_fall |=> !sck_out);
    // R6: divider select held inside the high half
    a_r6_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HIGH && !tick_w && active) |=> $stable(div_q));
endmodule

// File: tb/test_sck_rate_gen.sv
module test_sck_rate_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       rate_wr = 0;
    logic [7:0] rate_wdata = 0;
    logic [1:0] div_sel = 0;
    logic       master_sel = 0;
    logic       gen_en = 0;
    logic sck_out, sck_active, half_tick, sck_rise, sck_fall;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sck_rate_gen i_sck_rate_gen (
        .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
        .div_sel(div_sel), .master_sel(master_sel), .gen_en(gen_en),
        .sck_out(sck_out), .sck_active(sck_active), .half_tick(half_tick),
        .sck_rise(sck_rise), .sck_fall(sck_fall)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_rate(input int v);
        @(negedge clk);
        rate_wr = 1; rate_wdata = 8'(v);
        @(negedge clk);
        rate_wr = 0;
    endtask

    // cycles from the current negedge until a strobe is seen
    task automatic wait_rise(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk); cyc++;
        end while (!sck_rise && cyc < 20000);
    endtask

    task automatic wait_fall(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk); cyc++;
        end while (!sck_fall && cyc < 20000);
    endtask

    task automatic stop_gen;
        @(negedge clk);
        gen_en = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic measure(input string req, input int n, input int dv, input bit do_write);
        int c;
        int half;
        half = (n + 1) << dv;
        stop_gen();
        if (do_write) write_rate(n);
        div_sel = 2'(dv); master_sel = 1; gen_en = 1;
        wait_rise(c);
        @(negedge clk); c = 1;
        check({req, " R7 sck high after rise"}, sck_out, 1);
        while (!sck_fall && c < 20000) begin @(negedge clk); c++; end
        check({req, " R2 high half"}, c, half);
        wait_rise(c);
        check({req, " R2 low half"}, c, half);
        wait_rise(c);
        check({req, " R2 full period"}, c, 2 * half);
    endtask

    task automatic t_reset;
        check("R1 sck_out", sck_out, 0);
        check("R1 sck_active", sck_active, 0);
        check("R1 strobes", int'(sck_rise | sck_fall | half_tick), 0);
        measure("R1 reset rate", 255, 0, 0);
    endtask

    task automatic t_ranges;
        measure("R3 n0 N0", 0, 0, 1);
        measure("R3 n2 N0", 2, 0, 1);
        measure("R3 n5 N2", 5, 2, 1);
        measure("R3 n255 N3", 255, 3, 1);
        measure("R2 n17 N1", 17, 1, 1);
        measure("R2 n0 N3", 0, 3, 1);
    endtask

    task automatic t_write_lock;
        measure("R4 base", 3, 0, 1);
        @(negedge clk);
        rate_wr = 1; rate_wdata = 8'd10;
        @(negedge clk);
        rate_wr = 0;
        measure("R4 locked write ignored", 3, 0, 0);
        stop_gen();
        master_sel = 0; gen_en = 1;
        write_rate(6);
        gen_en = 0;
        measure("R4 slave write accepted", 6, 0, 0);
    endtask

    task automatic t_idle;
        int seen;
        stop_gen();
        write_rate(0);
        master_sel = 0; gen_en = 1; div_sel = 0;
        seen = 0;
        repeat (40) begin
            @(negedge clk);
            seen |= int'(sck_out | sck_active | half_tick | sck_rise | sck_fall);
        end
        check("R5 slave mode quiet", seen, 0);
        master_sel = 1; gen_en = 1;
        repeat (7) @(negedge clk);
        gen_en = 0;
        @(negedge clk);
        seen = 0;
        repeat (20) begin
            @(negedge clk);
            seen |= int'(sck_out | sck_active | half_tick | sck_rise | sck_fall);
        end
        check("R5 disabled quiet", seen, 0);
    endtask

    task automatic t_div_change;
        int c;
        stop_gen();
        write_rate(3);
        div_sel = 0; master_sel = 1; gen_en = 1;
        wait_rise(c);
        div_sel = 2;
        wait_fall(c);
        check("R6 high half keeps old length", c, 4);
        wait_rise(c);
        check("R6 new length after boundary", c, 16);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ranges();
        t_write_lock();
        t_idle();
        t_div_change();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule